// File: doc/BRIEF.md
# Per-Slot Network Interrupt Aggregator

This block gathers interrupt requests from the ports of plug-in module slots into status words and drives one summary interrupt line toward the CPU. An interrupt source sends a set strobe with its slot and port number. A clear strobe with the same pair removes the request. The host reads the status words through a small combinational read port. From the result it works out which slot and port raised the interrupt.

A static chassis-variant input selects one of two slot layouts. The four-slot layout keeps every request in one 32-bit word, which the host reads as four byte registers. The slots appear in those registers in an interleaved order. The seven-slot layout gives each slot four request lines. It uses two words: the first is read as a full 32-bit value and the second as one byte. Slot offsets are interleaved in this layout too. The summary interrupt is registered.

Top module: `netirq_aggregator`

## Requirements
- R1: After reset both status words are zero, `irq_o` is low and every read address returns zero.
- R2: With `variant_i`=0 (four-slot), a request for slot s (0..3) and port p (0..7) targets bit base+p of word 0, where base is 16 for slot 0, 24 for slot 1, 0 for slot 2 and 8 for slot 3.
- R3: With `variant_i`=0, read address 0 returns word 0 bits 31:24, address 1 returns bits 23:16, address 2 returns bits 15:8 and address 3 returns bits 7:0, each zero-extended to 32 bits. Addresses 4..7 return zero.
- R4: With `variant_i`=1 (seven-slot), ports run 0..3. Slot 0 targets bit p of word 1. Slots 1 to 6 target bit base+p of word 0, with base 24, 16, 28, 20, 8 and 0 for slots 1, 2, 3, 4, 5 and 6.
- R5: With `variant_i`=1, read address 4 returns all of word 0 and address 5 returns word 1 bits 7:0, zero-extended. All other addresses return zero.
- R6: A set strobe makes its target bit one and a clear strobe makes its target bit zero, one cycle after the strobe. No other status bit changes.
- R7: When a set and a clear arrive in the same cycle and name the same bit, the bit ends up set. When they name different bits, both take effect.
- R8: A request with no target leaves every status bit unchanged. In the four-slot layout this is any slot from 4 to 7. In the seven-slot layout it is slot 7 or any port from 4 to 7.
- R9: `irq_o` is a register. One cycle after a clock edge it shows whether the status words held after that edge contain a set bit: word 0 alone in the four-slot layout, either word in the seven-slot layout.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| variant_i | input | 1 | 0 = four-slot layout, 1 = seven-slot layout; held static |
| set_vld_i | input | 1 | Set strobe |
| set_slot_i | input | 3 | Slot of the set request |
| set_port_i | input | 3 | Port of the set request |
| clr_vld_i | input | 1 | Clear strobe |
| clr_slot_i | input | 3 | Slot of the clear request |
| clr_port_i | input | 3 | Port of the clear request |
| rd_addr_i | input | 3 | Host read address |
| rd_data_o | output | 32 | Host read data (combinational) |
| irq_o | output | 1 | Summary interrupt |

## Verification
The bench drives every slot and port into each layout's interleaved offsets. A design with a swapped base table would set a bit in the wrong byte lane, and the readout sweep would show that. It also sends a set and a clear for the same bit in one cycle; if the clear won, that bit would read back as zero. Requests to slots that do not exist, and ports beyond the fourth in the seven-slot layout, must leave every register unchanged. A design that wraps the bit index would corrupt a neighbouring slot instead. The bench also checks `irq_o` one cycle after the last bit clears. A combinational or two-stage interrupt path would drop or hold the line in the wrong cycle, and an interrupt that ignored word 1 would stay quiet for seven-slot slot 0.

// File: rtl/netirq_pkg.sv
package netirq_pkg;
  localparam int WORD_W    = 32;
  localparam int NUM_WORDS = 2;
  localparam int SLOT_W    = 3;
  localparam int PORT_W    = 3;
  localparam int ADDR_W    = 3;
  localparam int IDX_W     = $clog2(WORD_W);
  localparam int BYTE_W    = 8;

  typedef enum logic {VAR_FOUR = 1'b0, VAR_SEVEN = 1'b1} variant_e;

  typedef struct packed {
    logic             hit;
    logic             word;
    logic [IDX_W-1:0] idx;
  } bit_loc_t;

  // Base offset of a slot in the four-slot layout (slots interleaved)
  function automatic logic [IDX_W-1:0] four_base(input logic [SLOT_W-1:0] slot);
    case (slot[1:0])
      2'd0:    four_base = IDX_W'(16);
      2'd1:    four_base = IDX_W'(24);
      2'd2:    four_base = IDX_W'(0);
      default: four_base = IDX_W'(8);
    endcase
  endfunction

  // Base offset of a slot in the seven-slot layout
  function automatic logic [IDX_W-1:0] seven_base(input logic [SLOT_W-1:0] slot);
    case (slot)
      3'd1:    seven_base = IDX_W'(24);
      3'd2:    seven_base = IDX_W'(16);
      3'd3:    seven_base = IDX_W'(28);
      3'd4:    seven_base = IDX_W'(20);
      3'd5:    seven_base = IDX_W'(8);
      default: seven_base = IDX_W'(0);
    endcase
  endfunction
endpackage

// File: rtl/netirq_locate.sv
module netirq_locate
  import netirq_pkg::*;
(
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              variant_i,
  input  logic                              vld_i,
  input  logic [SLOT_W-1:0]                 slot_i,
  input  logic [PORT_W-1:0]                 port_i,
  output logic [NUM_WORDS-1:0][WORD_W-1:0]  mask_o
);
  localparam int FOUR_SLOTS  = 4;
  localparam int SEVEN_SLOTS = 7;
  localparam int SEVEN_PORTS = 4;

  bit_loc_t loc;

  always_comb begin
    loc = '0;
    if (variant_i == VAR_FOUR) begin
      loc.hit  = (int'(slot_i) < FOUR_SLOTS);
      loc.word = 1'b0;
      loc.idx  = four_base(slot_i) + IDX_W'(port_i);
    end else begin
      loc.hit  = (int'(slot_i) < SEVEN_SLOTS) && (int'(port_i) < SEVEN_PORTS);
      loc.word = (slot_i == '0);
      loc.idx  = seven_base(slot_i) + IDX_W'(port_i);
    end
  end

  for (genvar w = 0; w < NUM_WORDS; w++) begin : g_word
    always_comb begin
      mask_o[w] = '0;
      if (vld_i && loc.hit && (loc.word == w[0]))
        mask_o[w][loc.idx] = 1'b1;
    end
  end

  // R6
  one_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(mask_o));

  // R8
  four_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (variant_i == VAR_FOUR && int'(slot_i) >= FOUR_SLOTS) |-> (mask_o == '0));
endmodule

// File: rtl/netirq_status.sv
module netirq_status
  import netirq_pkg::*;
(
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic [NUM_WORDS-1:0][WORD_W-1:0]  set_mask_i,
  input  logic [NUM_WORDS-1:0][WORD_W-1:0]  clr_mask_i,
  output logic [NUM_WORDS-1:0][WORD_W-1:0]  word_o
);
  logic [NUM_WORDS-1:0][WORD_W-1:0] word_q, word_d;
  logic [NUM_WORDS-1:0]             word_en;

  for (genvar w = 0; w < NUM_WORDS; w++) begin : g_word
    always_comb begin
      word_en[w] = (|set_mask_i[w]) | (|clr_mask_i[w]);
      word_d[w]  = (word_q[w] & ~clr_mask_i[w]) | set_mask_i[w];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        word_q[w] <= '0;
      else if (word_en[w])
        word_q[w] <= word_d[w];
    end

    // R6 R7
    set_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (|set_mask_i[w]) |=>
        ((word_q[w] & $past(set_mask_i[w])) == $past(set_mask_i[w])));

    // R6
    clr_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (|(clr_mask_i[w] & ~set_mask_i[w])) |=>
        ((word_q[w] & $past(clr_mask_i[w] & ~set_mask_i[w])) == '0));

    // R6 R8
    others_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (((word_q[w] ^ $past(word_q[w])) &
                 ~$past(set_mask_i[w] | clr_mask_i[w])) == '0));
  end

  assign word_o = word_q;
endmodule

// File: rtl/netirq_readout.sv
module netirq_readout
  import netirq_pkg::*;
(
  input  logic                              variant_i,
  input  logic [NUM_WORDS-1:0][WORD_W-1:0]  word_i,
  input  logic [ADDR_W-1:0]                 addr_i,
  output logic [WORD_W-1:0]                 data_o
);
  localparam int NUM_LANES   = WORD_W / BYTE_W;
  localparam int WIDE_ADDR   = 4;
  localparam int NARROW_ADDR = 5;

  logic [NUM_LANES-1:0][BYTE_W-1:0] lanes;
  assign lanes = word_i[0];

  always_comb begin
    data_o = '0;
    if (variant_i == VAR_FOUR) begin
      if (int'(addr_i) < NUM_LANES)
        data_o = WORD_W'(lanes[NUM_LANES-1-int'(addr_i)]);
    end else begin
      if (int'(addr_i) == WIDE_ADDR)
        data_o = word_i[0];
      else if (int'(addr_i) == NARROW_ADDR)
        data_o = WORD_W'(word_i[1][BYTE_W-1:0]);
    end
  end
endmodule

// File: rtl/netirq_aggregator.sv
module netirq_aggregator
  import netirq_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                variant_i,
  input  logic                set_vld_i,
  input  logic [SLOT_W-1:0]   set_slot_i,
  input  logic [PORT_W-1:0]   set_port_i,
  input  logic                clr_vld_i,
  input  logic [SLOT_W-1:0]   clr_slot_i,
  input  logic [PORT_W-1:0]   clr_port_i,
  input  logic [ADDR_W-1:0]   rd_addr_i,
  output logic [WORD_W-1:0]   rd_data_o,
  output logic                irq_o
);
  localparam int NUM_REQ = 2;  // 0 = set, 1 = clear

  logic [NUM_REQ-1:0]                            req_vld;
  logic [NUM_REQ-1:0][SLOT_W-1:0]                req_slot;
  logic [NUM_REQ-1:0][PORT_W-1:0]                req_port;
  logic [NUM_REQ-1:0][NUM_WORDS-1:0][WORD_W-1:0] req_mask;
  logic [NUM_WORDS-1:0][WORD_W-1:0]              words;
  logic                                          irq_d, irq_q;

  assign req_vld  = {clr_vld_i,  set_vld_i};
  assign req_slot = {clr_slot_i, set_slot_i};
  assign req_port = {clr_port_i, set_port_i};

  for (genvar r = 0; r < NUM_REQ; r++) begin : g_req
    netirq_locate u_locate (
      .clk       (clk),
      .rst_n     (rst_n),
      .variant_i (variant_i),
      .vld_i     (req_vld[r]),
      .slot_i    (req_slot[r]),
      .port_i    (req_port[r]),
      .mask_o    (req_mask[r])
    );
  end

  netirq_status u_status (
    .clk        (clk),
    .rst_n      (rst_n),
    .set_mask_i (req_mask[0]),
    .clr_mask_i (req_mask[1]),
    .word_o     (words)
  );

  netirq_readout u_readout (
    .variant_i (variant_i),
    .word_i    (words),
    .addr_i    (rd_addr_i),
    .data_o    (rd_data_o)
  );

  always_comb begin
    irq_d = |words[0];
    if (variant_i == VAR_SEVEN)
      irq_d = irq_d | (|words[1]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      irq_q <= 1'b0;
    else
      irq_q <= irq_d;
  end

  assign irq_o = irq_q;

  // R9
  irq_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(words) == '0) |-> !irq_o);

  // R9
  irq_word0_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (words[0] != '0) |=> irq_o);
endmodule

// File: tb/sim_netirq_aggregator.sv
module sim_netirq_aggregator;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        variant_i = 1'b0;
  logic        set_vld_i = 1'b0, clr_vld_i = 1'b0;
  logic [2:0]  set_slot_i = '0, set_port_i = '0, clr_slot_i = '0, clr_port_i = '0;
  logic [2:0]  rd_addr_i = '0;
  logic [31:0] rd_data_o;
  logic        irq_o;

  int tests = 0, fails = 0;
  logic [31:0] m0, m1;

  always #10 clk = ~clk;  // 50 MHz

  netirq_aggregator u0 (.*);

  // Expected target: returns 1 on a hit, with word w and bit b
  function automatic bit target(input bit v, input int s, input int p,
                                output int w, output int b);
    w = 0; b = 0;
    if (!v) begin
      if (s > 3) return 0;
      case (s) 0: b = 16; 1: b = 24; 2: b = 0; default: b = 8; endcase
      b = b + p;
      return 1;
    end
    if (s > 6 || p > 3) return 0;
    case (s) 0: begin w = 1; b = 0; end 1: b = 24; 2: b = 16; 3: b = 28;
      4: b = 20; 5: b = 8; default: b = 0; endcase
    b = b + p;
    return 1;
  endfunction

  function automatic logic [31:0] exp_read(input bit v, input int a);
    if (!v) begin
      case (a) 0: return {24'd0, m0[31:24]}; 1: return {24'd0, m0[23:16]};
        2: return {24'd0, m0[15:8]}; 3: return {24'd0, m0[7:0]};
        default: return 32'd0; endcase
    end
    if (a == 4) return m0;
    if (a == 5) return {24'd0, m1[7:0]};
    return 32'd0;
  endfunction

  function automatic bit exp_nz(input bit v);
    return v ? ((m0 | m1) != 0) : (m0 != 0);
  endfunction

  task automatic check_reads(input string tag);
    for (int a = 0; a < 8; a++) begin
      rd_addr_i = 3'(a);
      #1;
      tests++;
      if (rd_data_o !== exp_read(variant_i, a)) begin
        fails++;
        $display("FAIL %s addr %0d: actual %h expected %h", tag, a, rd_data_o,
                 exp_read(variant_i, a));
      end
    end
  endtask

  task automatic do_reset(input bit v);
    @(negedge clk);
    rst_n = 1'b0; variant_i = v; set_vld_i = 0; clr_vld_i = 0;
    m0 = '0; m1 = '0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    // R1: reset state
    check_reads("R1");
    tests++;
    if (irq_o !== 1'b0) begin
      fails++; $display("FAIL R1 irq: actual %b expected 0", irq_o);
    end
  endtask

  task automatic step(input bit sv, input int ss, input int sp,
                      input bit cv, input int cs, input int cp, input string tag);
    int w, b;
    bit prev_nz;
    set_vld_i = sv; set_slot_i = 3'(ss); set_port_i = 3'(sp);
    clr_vld_i = cv; clr_slot_i = 3'(cs); clr_port_i = 3'(cp);
    @(posedge clk);
    prev_nz = exp_nz(variant_i);
    // clear first, then set: the set wins on the same bit (R7)
    if (cv && target(variant_i, cs, cp, w, b)) begin
      if (w == 0) m0[b] = 1'b0; else m1[b] = 1'b0;
    end
    if (sv && target(variant_i, ss, sp, w, b)) begin
      if (w == 0) m0[b] = 1'b1; else m1[b] = 1'b1;
    end
    @(negedge clk);
    set_vld_i = 0; clr_vld_i = 0;
    check_reads(tag);
    // R9: irq reflects the status held after the previous edge
    tests++;
    if (irq_o !== prev_nz) begin
      fails++; $display("FAIL R9 (%s) irq: actual %b expected %b", tag, irq_o, prev_nz);
    end
  endtask

  task automatic drain(input string tag);
    step(0, 0, 0, 0, 0, 0, tag);
    step(0, 0, 0, 0, 0, 0, tag);
  endtask

  initial begin
    void'($urandom(32'h5eed_1234));
    // ---- four-slot layout ----
    do_reset(1'b0);
    // R2 R3: every slot/port of the four-slot layout, one at a time
    for (int s = 0; s < 4; s++)
      for (int p = 0; p < 8; p++) begin
        step(1, s, p, 0, 0, 0, "R2");
        step(0, 0, 0, 1, s, p, "R3");
      end
    drain("R9");
    // R8: slots 4..7 ignored
    step(1, 1, 2, 0, 0, 0, "R8");
    for (int s = 4; s < 8; s++) step(1, s, s, 1, s, 0, "R8");
    // R7: set and clear of the same bit, then of different bits
    step(1, 1, 2, 1, 1, 2, "R7");
    step(1, 3, 7, 1, 1, 2, "R7");
    step(0, 0, 0, 1, 3, 7, "R6");
    drain("R9");
    for (int i = 0; i < 300; i++)
      step($urandom_range(1, 0), $urandom_range(7, 0), $urandom_range(7, 0),
           $urandom_range(1, 0), $urandom_range(7, 0), $urandom_range(7, 0), "R6");
    // ---- seven-slot layout ----
    do_reset(1'b1);
    // R4 R5
    for (int s = 0; s < 7; s++)
      for (int p = 0; p < 4; p++) begin
        step(1, s, p, 0, 0, 0, "R4");
        step(0, 0, 0, 1, s, p, "R5");
      end
    // R9: slot 0 lives in word 1 and must raise the interrupt alone
    step(1, 0, 3, 0, 0, 0, "R9");
    drain("R9");
    step(0, 0, 0, 1, 0, 3, "R9");
    drain("R9");
    // R8: slot 7 and ports 4..7 ignored
    step(1, 6, 1, 0, 0, 0, "R8");
    step(1, 7, 0, 1, 7, 1, "R8");
    for (int p = 4; p < 8; p++) step(1, p - 4, p, 1, 6, p, "R8");
    step(1, 0, 1, 1, 0, 1, "R7");
    for (int i = 0; i < 300; i++)
      step($urandom_range(1, 0), $urandom_range(7, 0), $urandom_range(7, 0),
           $urandom_range(1, 0), $urandom_range(7, 0), $urandom_range(7, 0), "R6");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #(20 * 150000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule